// File: doc/BRIEF.md
# Absolute Encoder Serial Frame Reader

This block reads an absolute position encoder over a unidirectional BiSS-C link, in which the master only clocks and the slave only answers. One request starts a burst of `BURST_LEN` master clock pulses. The clock idles high. Each low and each high level lasts `HALF_DIV` system cycles. The return data line is sampled on every rising edge of that clock into a capture register, at an index equal to the pulse number.

The frame is parsed only after the whole burst has been captured. A priority scan, which works like a count of trailing zeros, finds the start bit. It is the lowest asserted sample at or above index `ACK_SKIP`, so the idle-high samples at the head of the burst are passed over. A serial walker then reads the rest of the frame in order: the CDS bit, the position word MSB first with a width set by `data_bits_i`, two active-low status bits, and a 6-bit CRC. It checks the CRC and reports the result with a one-cycle done pulse. Position and flags change only on a frame that is good.

Top module: `abs_enc_link`

## Requirements
- R1: `enc_clk_o` is high after reset and whenever no transaction is running. During a burst each low level lasts exactly `HALF_DIV` clock cycles.
- R2: Every accepted request produces exactly `BURST_LEN` rising edges on `enc_clk_o`. A request made while a burst or parse is in progress is ignored, including the `data_bits_i` value offered with it, and produces no extra done pulse.
- R3: The data line is sampled once at each rising edge of `enc_clk_o`. Sample k (counting from 0) holds the level driven before rising edge k+1.
- R4: The start bit is the lowest-indexed sample equal to 1 at index `ACK_SKIP` (default 2) or above. High samples below that index are ignored.
- R5: After the start bit the frame is: one CDS bit (not checked), then `data_bits_i` position bits MSB first, then an active-low error bit, then an active-low warning bit, then 6 CRC bits MSB first. `alarm_o` is the inverse of the error bit and `warn_o` is the inverse of the warning bit.
- R6: The CRC runs serially over the position bits and then the two status bits. It uses polynomial x^6+x+1 (feedback = input XOR bit 5; shift left; XOR 6'h03 when feedback is 1) from a zero seed. The transmitted field is the bitwise inverse of the result. `crc_ok_o` is 1 exactly when the two match.
- R7: On a parsed frame whose CRC fails, `crc_ok_o` is 0, `frame_err_o` is 0, and `pos_o`, `alarm_o` and `warn_o` keep their previous values.
- R8: `frame_err_o` is 1 and `crc_ok_o` is 0, with position and flags held, when any of these is true: no start bit is found; `data_bits_i` is 0 or greater than `DW_MAX`; or the frame does not fit, that is start index + `data_bits_i` + 10 > `BURST_LEN`.
- R9: `done_o` is a single-cycle pulse, one per accepted request, issued after parsing. All result outputs are valid in that cycle.
- R10: With `data_bits_i` = 17, `pos_o` carries the full 17-bit range 0 to 131071 and the upper bits are zero.
- R11: After reset `pos_o` is 0, all flags are 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a position read |
| data_bits_i | input | $clog2(DW_MAX+1) | Position word width, latched when a request is accepted |
| enc_data_i | input | 1 | Return data line from the encoder |
| enc_clk_o | output | 1 | Master clock to the encoder, idles high |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| pos_o | output | DW_MAX | Last valid position, right-aligned |
| alarm_o | output | 1 | Encoder error flag, active high |
| warn_o | output | 1 | Encoder warning flag, active high |
| crc_ok_o | output | 1 | Last parsed frame passed its CRC |
| frame_err_o | output | 1 | Last transaction had no usable frame |

## Verification
The encoder model answers with frames of widths 1, 12, 17 and 32 bits, with acknowledge delays from zero up to the fitting limit. These cases tell a correct start-bit scan and correct variable-width extraction apart from off-by-one errors in either. Frames of all-ones and all-zeros position, and frames with each status bit asserted on its own, separate the ordering of data, error and warning bits. A single flipped CRC bit, a frame with no start bit, an oversize width, and delays one sample either side of the fit boundary separate a held position from an updated one. A second request issued mid-burst, carrying a different width, shows that busy requests are dropped.

// File: rtl/abs_enc_pkg.sv
package abs_enc_pkg;

    typedef enum logic [1:0] {K_IDLE, K_LOW, K_HIGH} clk_st_e;
    typedef enum logic [2:0] {W_IDLE, W_CDS, W_DATA, W_STAT, W_CRC} walk_st_e;

    // one serial step of the x^6 + x + 1 check, zero seed applied by caller
    function automatic logic [5:0] crc6_step(logic [5:0] c, logic b);
        logic fb;
        fb = b ^ c[5];
        return {c[4:0], 1'b0} ^ (fb ? 6'h03 : 6'h00);
    endfunction

endpackage

// File: rtl/enc_clk_burst.sv
module enc_clk_burst
    import abs_enc_pkg::*;
#(
    parameter int HALF   = 2,
    parameter int NPULSE = 48,
    parameter int IW     = $clog2(NPULSE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          sclk_o,
    output logic          stb_o,
    output logic [IW-1:0] idx_o,
    output logic          last_o
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        clk_st_e       st;
        logic [HW-1:0] cnt;
        logic [IW-1:0] pls;
        logic          sclk;
        logic          last;
    } burst_t;

    burst_t q, d;

    always_comb begin
        d      = q;
        d.last = 1'b0;
        stb_o  = 1'b0;
        case (q.st)
            K_IDLE: if (start_i) begin
                d.st   = K_LOW;
                d.sclk = 1'b0;
                d.cnt  = '0;
                d.pls  = '0;
            end
            K_LOW: if (q.cnt == HW'(HALF - 1)) begin
                d.st   = K_HIGH;
                d.sclk = 1'b1;
                d.cnt  = '0;
                stb_o  = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
            K_HIGH: if (q.cnt == HW'(HALF - 1)) begin
                d.cnt = '0;
                if (q.pls == IW'(NPULSE - 1)) begin
                    d.st   = K_IDLE;
                    d.last = 1'b1;
                end else begin
                    d.st   = K_LOW;
                    d.sclk = 1'b0;
                    d.pls  = q.pls + 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
            default: d.st = K_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= K_IDLE;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_o = q.sclk;
    assign idx_o  = q.pls;
    assign last_o = q.last;

    // R2: pulse counter never runs past the burst length
    p_pls_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.pls < IW'(NPULSE));
    // R3: every rising edge of the master clock comes with a capture strobe
    p_rise_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $past(stb_o));

endmodule

// File: rtl/enc_start_find.sv
module enc_start_find #(
    parameter int N    = 48,
    parameter int SKIP = 2,
    parameter int IW   = $clog2(N + 1)
) (
    input  logic [N-1:0]  cap_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // trailing-zero style scan: lowest set bit at or above SKIP wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (i >= SKIP && cap_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/enc_frame_walk.sv
module enc_frame_walk
    import abs_enc_pkg::*;
#(
    parameter int N   = 48,
    parameter int DWM = 32,
    parameter int IW  = $clog2(N + 1),
    parameter int BW  = $clog2(DWM + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           found_i,
    input  logic [IW-1:0]  sidx_i,
    input  logic [N-1:0]   cap_i,
    input  logic [BW-1:0]  dw_i,
    output logic           done_o,
    output logic [DWM-1:0] pos_o,
    output logic           alarm_o,
    output logic           warn_o,
    output logic           crc_ok_o,
    output logic           ferr_o
);
    localparam int CW = (BW > 3) ? BW : 3;

    typedef struct packed {
        walk_st_e       st;
        logic [IW-1:0]  idx;
        logic [CW-1:0]  cnt;
        logic [DWM-1:0] sh;
        logic [5:0]     crc;
        logic [5:0]     rxc;
        logic           ne;
        logic           nw;
        logic [DWM-1:0] pos;
        logic           alarm;
        logic           warn;
        logic           ok;
        logic           ferr;
        logic           done;
    } walk_t;

    walk_t q, d;
    logic  bit_s;
    logic  bad_dw, fits;

    assign bit_s  = cap_i[q.idx];
    assign bad_dw = (dw_i == '0) || (int'(dw_i) > DWM);
    assign fits   = (int'(sidx_i) + int'(dw_i) + 10) <= N;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            W_IDLE: if (start_i) begin
                if (!found_i || bad_dw || !fits) begin
                    d.done = 1'b1;
                    d.ferr = 1'b1;
                    d.ok   = 1'b0;
                end else begin
                    d.st  = W_CDS;
                    d.idx = sidx_i + 1'b1;
                    d.cnt = '0;
                    d.sh  = '0;
                    d.crc = '0;
                    d.rxc = '0;
                end
            end
            W_CDS: begin
                d.idx = q.idx + 1'b1;
                d.st  = W_DATA;
            end
            W_DATA: begin
                d.sh  = {q.sh[DWM-2:0], bit_s};
                d.crc = crc6_step(q.crc, bit_s);
                d.idx = q.idx + 1'b1;
                if (q.cnt == CW'(dw_i) - 1'b1) begin
                    d.cnt = '0;
                    d.st  = W_STAT;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            W_STAT: begin
                d.crc = crc6_step(q.crc, bit_s);
                d.idx = q.idx + 1'b1;
                if (q.cnt == '0) begin
                    d.ne  = bit_s;
                    d.cnt = q.cnt + 1'b1;
                end else begin
                    d.nw  = bit_s;
                    d.cnt = '0;
                    d.st  = W_CRC;
                end
            end
            W_CRC: begin
                d.rxc = {q.rxc[4:0], bit_s};
                d.idx = q.idx + 1'b1;
                if (q.cnt == CW'(5)) begin
                    d.st   = W_IDLE;
                    d.cnt  = '0;
                    d.done = 1'b1;
                    d.ferr = 1'b0;
                    d.ok   = ({q.rxc[4:0], bit_s} == ~q.crc);
                    if ({q.rxc[4:0], bit_s} == ~q.crc) begin
                        d.pos   = q.sh;
                        d.alarm = ~q.ne;
                        d.warn  = ~q.nw;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= W_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done_o   = q.done;
    assign pos_o    = q.pos;
    assign alarm_o  = q.alarm;
    assign warn_o   = q.warn;
    assign crc_ok_o = q.ok;
    assign ferr_o   = q.ferr;

    // R9: result strobe lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8: an unusable frame leaves the position alone
    p_hold_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ferr_o) |-> (pos_o == $past(pos_o)));
    // R7: a CRC failure leaves the position alone
    p_hold_crc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !crc_ok_o) |-> (pos_o == $past(pos_o)));
    // R5: the walker never reads past the captured window
    p_walk_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != W_IDLE) |-> (q.idx < IW'(N)));

endmodule

// File: rtl/abs_enc_link.sv
module abs_enc_link
    import abs_enc_pkg::*;
#(
    parameter int DW_MAX    = 32,
    parameter int BURST_LEN = 48,
    parameter int HALF_DIV  = 2,
    parameter int ACK_SKIP  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    input  logic [$clog2(DW_MAX+1)-1:0]  data_bits_i,
    input  logic                         enc_data_i,
    output logic                         enc_clk_o,
    output logic                         done_o,
    output logic [DW_MAX-1:0]            pos_o,
    output logic                         alarm_o,
    output logic                         warn_o,
    output logic                         crc_ok_o,
    output logic                         frame_err_o
);
    localparam int IW = $clog2(BURST_LEN + 1);
    localparam int BW = $clog2(DW_MAX + 1);

    typedef struct packed {
        logic                 busy;
        logic [BW-1:0]        dw;
        logic [BURST_LEN-1:0] cap;
    } top_t;

    top_t q, d;

    logic          go, smp_stb, burst_end, found;
    logic [IW-1:0] smp_idx, start_idx;

    assign go = req_i && !q.busy;

    always_comb begin
        d = q;
        if (go) begin
            d.busy = 1'b1;
            d.dw   = data_bits_i;
        end
        if (smp_stb) d.cap[smp_idx] = enc_data_i;
        if (done_o)  d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    enc_clk_burst #(.HALF(HALF_DIV), .NPULSE(BURST_LEN), .IW(IW)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(go),
        .sclk_o (enc_clk_o),
        .stb_o  (smp_stb),
        .idx_o  (smp_idx),
        .last_o (burst_end)
    );

    enc_start_find #(.N(BURST_LEN), .SKIP(ACK_SKIP), .IW(IW)) u_find (
        .cap_i  (q.cap),
        .found_o(found),
        .idx_o  (start_idx)
    );

    enc_frame_walk #(.N(BURST_LEN), .DWM(DW_MAX), .IW(IW), .BW(BW)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (burst_end),
        .found_i (found),
        .sidx_i  (start_idx),
        .cap_i   (q.cap),
        .dw_i    (q.dw),
        .done_o  (done_o),
        .pos_o   (pos_o),
        .alarm_o (alarm_o),
        .warn_o  (warn_o),
        .crc_ok_o(crc_ok_o),
        .ferr_o  (frame_err_o)
    );

    // R1: master clock stays high outside a transaction
    p_clk_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> enc_clk_o);
    // R3: captures happen only inside a transaction
    p_strobe_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> q.busy);
    // R2: latched width cannot change while busy
    p_ignore_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> $stable(q.dw));

endmodule

// File: tb/sim_abs_enc_link.sv
module sim_abs_enc_link;
    import abs_enc_pkg::*;

    localparam int DWM  = 32;
    localparam int NB   = 48;
    localparam int HD   = 2;
    localparam int SKIP = 2;
    localparam int FRSZ = 80;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req = 1'b0;
    logic [5:0]      dbits = '0;
    logic            sl = 1'b1;
    logic            enc_clk, done, alarm, warn, crc_ok, ferr;
    logic [DWM-1:0]  pos;

    abs_enc_link #(.DW_MAX(DWM), .BURST_LEN(NB), .HALF_DIV(HD), .ACK_SKIP(SKIP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .data_bits_i(dbits),
        .enc_data_i(sl), .enc_clk_o(enc_clk), .done_o(done), .pos_o(pos),
        .alarm_o(alarm), .warn_o(warn), .crc_ok_o(crc_ok), .frame_err_o(ferr)
    );

    typedef struct {
        logic [31:0] pos;
        bit          al;
        bit          wa;
        bit          ok;
        bit          fe;
        string       lbl;
    } exp_t;

    exp_t        sb[$];
    int          ntest = 0, nfail = 0;
    logic        fr[FRSZ];
    int          k = 0, rises = 0, badw = 0, lowrun = 0;
    logic [31:0] last_pos = '0;
    bit          last_al = 0, last_wa = 0;
    bit          finished = 0;

    initial forever #4 clk = ~clk;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        ntest++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_step(logic [5:0] c, logic b);
        logic [5:0] n;
        n = {c[4:0], 1'b0};
        if (b ^ c[5]) n = n ^ 6'b000011;
        return n;
    endfunction

    // encoder model: next frame bit appears at each falling master edge
    initial forever begin
        @(negedge enc_clk);
        sl = (k < FRSZ) ? fr[k] : 1'b0;
        k++;
    end

    // monitor / scoreboard
    initial begin
        bit   prev_done;
        logic prev_clk;
        exp_t e;
        prev_done = 0;
        prev_clk  = 1'b1;
        forever begin
            @(negedge clk);
            if (enc_clk === 1'b0) lowrun++;
            if (prev_clk === 1'b0 && enc_clk === 1'b1) begin
                rises++;
                if (lowrun != HD) badw++;
                lowrun = 0;
            end
            prev_clk = enc_clk;
            if (prev_done) chk("R9 done longer than one cycle", done, 0);
            if (done === 1'b1) begin
                if (sb.size() == 0) begin
                    chk("R2 done with no accepted request", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk({"R7/R10 pos ", e.lbl}, pos, e.pos);
                    chk({"R5 alarm ", e.lbl}, alarm, e.al);
                    chk({"R5 warn ", e.lbl}, warn, e.wa);
                    chk({"R6 crc_ok ", e.lbl}, crc_ok, e.ok);
                    chk({"R8 frame_err ", e.lbl}, ferr, e.fe);
                    chk({"R2 pulse count ", e.lbl}, rises, NB);
                    chk({"R1 low width errors ", e.lbl}, badw, 0);
                end
            end
            prev_done = (done === 1'b1);
        end
    end

    task automatic run(string lbl, logic [31:0] p, int dw, bit ne, bit nw,
                       int ack, bit flip, bit nostart, bit extra);
        int          n;
        logic [5:0]  c, tx;
        logic [31:0] pm;
        bit          bad;
        exp_t        e;
        for (int i = 0; i < FRSZ; i++) fr[i] = 1'b0;
        fr[0] = 1'b1;
        fr[1] = 1'b1;
        n  = 2;
        c  = '0;
        pm = '0;
        if (!nostart) begin
            n += ack;
            fr[n++] = 1'b1;
            fr[n++] = 1'b0;
            for (int i = dw - 1; i >= 0; i--) begin
                fr[n++] = p[i];
                c = ref_step(c, p[i]);
                pm[i] = p[i];
            end
            fr[n++] = ne; c = ref_step(c, ne);
            fr[n++] = nw; c = ref_step(c, nw);
            tx = ~c;
            if (flip) tx[0] = ~tx[0];
            for (int j = 5; j >= 0; j--) fr[n++] = tx[j];
        end
        bad = nostart || dw < 1 || dw > DWM || (2 + ack + dw + 10 > NB);
        e.lbl = lbl;
        e.fe  = bad;
        e.ok  = !bad && !flip;
        if (e.ok) begin
            last_pos = pm;
            last_al  = !ne;
            last_wa  = !nw;
        end
        e.pos = last_pos;
        e.al  = last_al;
        e.wa  = last_wa;
        sb.push_back(e);
        k = 0; rises = 0; badw = 0; lowrun = 0; sl = 1'b1;
        @(negedge clk);
        req = 1'b1;
        dbits = 6'(dw);
        @(negedge clk);
        req = 1'b0;
        if (extra) begin
            repeat (30) @(negedge clk);
            req = 1'b1;
            dbits = 6'd5;
            @(negedge clk);
            req = 1'b0;
        end
        wait (sb.size() == 0);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state, R1 idle-high clock
        chk("R11 pos after reset", pos, 0);
        chk("R11 done after reset", done, 0);
        chk("R11 flags after reset", {alarm, warn, crc_ok, ferr}, 0);
        chk("R1 clock idle high", enc_clk, 1);

        run("R10 17-bit mid value R3",        32'h1ABCD,     17, 1, 1, 1, 0, 0, 0);
        run("R10 17-bit full scale alarm",     32'h1FFFF,     17, 0, 1, 3, 0, 0, 0);
        run("R10 17-bit zero warn",            32'h0,         17, 1, 0, 2, 0, 0, 0);
        run("R4 ack zero start at skip",       32'h00A5A,     12, 1, 1, 0, 0, 0, 0);
        run("R6 corrupted crc held",           32'h12345,     17, 0, 0, 1, 1, 0, 0);
        run("R8 no start bit",                 32'h0,         17, 1, 1, 1, 0, 1, 0);
        run("R8 truncated frame",              32'h00111,     17, 1, 1, 25, 0, 0, 0);
        run("R8 width zero",                   32'h0,         0,  1, 1, 1, 0, 0, 0);
        run("R8 width above max",              32'h0,         33, 1, 1, 1, 0, 0, 0);
        run("R8 exact fit 32-bit",             32'hDEADBEEF,  32, 1, 1, 4, 0, 0, 0);
        run("R8 one past fit",                 32'h0F0F0F0F,  32, 1, 1, 5, 0, 0, 0);
        run("R5 one-bit word",                 32'h1,         1,  1, 1, 2, 0, 0, 0);
        run("R2 busy request ignored",         32'h0C3A5,     17, 1, 1, 1, 0, 0, 1);
        repeat (300) @(negedge clk);
        chk("R2 no stray done", sb.size(), 0);
        chk("R1 clock idle high at end", enc_clk, 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            ntest++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

endmodule